// File: doc/BRIEF.md
# Token Ring Controller for Chained FIFO Slices

This block lets several FIFO slices act as one deeper FIFO. Each slice carries one copy. Write permission and read permission move around a closed ring of slices as two separate tokens. The slice that holds the write token is the only one allowed to store data. The slice that holds the read token is the only one allowed to deliver data. When the local memory reports that its final physical location has been written, the controller hands the write token to the next slice. When that location has been read, it hands on the read token in the same way. The outgoing pulses of the last slice feed the incoming pulses of the first slice, which closes the ring.

The operating mode is captured while reset is held. If the ring-link strap is low, the slice runs standalone: both enables stay high, the token pins stay idle, and the auxiliary features (half-full reporting and replay) are permitted. If the strap is high, the slice runs in ring mode, and those auxiliary features are disabled. In ring mode, the slice whose first-slice strap is low begins with both tokens. Every other slice begins with neither. Token pulses are active low and last one cycle. A pulse that arrives for a token the slice already holds is a protocol error. Such a pulse is flagged and leaves the token where it is.

Top module: `ring_tok_ctrl`

## Requirements
- R1: While rst_n is low, depth_mode follows ring_link. Once reset is released, depth_mode keeps that value whatever ring_link does afterwards.
- R2: At reset release in ring mode, wr_en and rd_en are both 1 when first_n was 0 and both 0 when first_n was 1. proto_err is 0 after reset.
- R3: In standalone mode, wr_en, rd_en and aux_en are 1, wtok_out_n and rtok_out_n are 1, and proto_err is 0, whatever the token and last-location inputs do.
- R4: In ring mode, wr_last=1 while the write token is held drives wtok_out_n to 0 in that same cycle, and wr_en is 0 from the next cycle on unless a write token arrives in that cycle.
- R5: In ring mode, rd_last=1 while the read token is held drives rtok_out_n to 0 in that same cycle, and rd_en is 0 from the next cycle on unless a read token arrives in that cycle.
- R6: In ring mode, wtok_in_n=0 while the write token is not held makes wr_en 1 from the next cycle. rtok_in_n=0 does the same for rd_en.
- R7: In ring mode, wr_last or rd_last asserted without the matching token produces no outgoing pulse and leaves the enables unchanged.
- R8: A token pulse that arrives for a token already held, and not being passed in that cycle, sets proto_err to 1 for exactly the next cycle and leaves the token held.
- R9: A token passed and received in the same cycle (the one-slice ring) stays held, and proto_err stays 0.
- R10: aux_en is 1 in standalone mode and 0 in ring mode.
- R11: The write token and the read token move independently. A pulse for one never changes the enable of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; the straps are sampled while it is low |
| ring_link | input | 1 | Mode strap: 1 selects ring mode, 0 selects standalone |
| first_n | input | 1 | First-slice strap, active low |
| wtok_in_n | input | 1 | Write-token pulse from the previous slice, active low |
| rtok_in_n | input | 1 | Read-token pulse from the previous slice, active low |
| wr_last | input | 1 | Local final physical location written this cycle |
| rd_last | input | 1 | Local final physical location read this cycle |
| wtok_out_n | output | 1 | Write-token pulse to the next slice, active low |
| rtok_out_n | output | 1 | Read-token pulse to the next slice, active low |
| wr_en | output | 1 | Write enable for the local FIFO |
| rd_en | output | 1 | Read enable and output-drive enable for the local FIFO |
| aux_en | output | 1 | Half-full reporting and replay permitted |
| depth_mode | output | 1 | Latched mode, 1 = ring mode |
| proto_err | output | 1 | One-cycle flag for a token pulse that arrived while the token was already held |

## Verification
The assertions assume three things about the inputs:
- reset is held for at least two cycles, so the latched mode is already in place when checking starts;
- token pulses and last-location strobes are sampled only at clock edges;
- no property relies on any particular pulse spacing.

The stimulus keeps within these assumptions. It holds reset for three cycles, and it changes every input at the falling clock edge. The random stimulus deliberately includes pulses that arrive for a token already held, and last-location strobes without the token. Both the error path and the ignore path are therefore exercised, not just legal ring traffic.

// File: rtl/ring_tok_ctrl.sv
module ring_tok_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ring_link,
  input  logic first_n,
  input  logic wtok_in_n,
  input  logic rtok_in_n,
  input  logic wr_last,
  input  logic rd_last,
  output logic wtok_out_n,
  output logic rtok_out_n,
  output logic wr_en,
  output logic rd_en,
  output logic aux_en,
  output logic depth_mode,
  output logic proto_err
);
  logic mode_q, wtok_q, rtok_q, err_q;

  wire w_pass = mode_q & wtok_q & wr_last;
  wire r_pass = mode_q & rtok_q & rd_last;
  wire w_rx   = mode_q & ~wtok_in_n;
  wire r_rx   = mode_q & ~rtok_in_n;
  wire w_bad  = w_rx & wtok_q & ~w_pass;
  wire r_bad  = r_rx & rtok_q & ~r_pass;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= ring_link;
      wtok_q <= ring_link & ~first_n;
      rtok_q <= ring_link & ~first_n;
      err_q  <= 1'b0;
    end else begin
      wtok_q <= w_rx | (wtok_q & ~w_pass);
      rtok_q <= r_rx | (rtok_q & ~r_pass);
      err_q  <= w_bad | r_bad;
    end
  end

  assign wtok_out_n = ~w_pass;
  assign rtok_out_n = ~r_pass;
  assign wr_en      = ~mode_q | wtok_q;
  assign rd_en      = ~mode_q | rtok_q;
  assign aux_en     = ~mode_q;
  assign depth_mode = mode_q;
  assign proto_err  = err_q;
endmodule

// File: rtl/ring_tok_ctrl_chk.sv
module ring_tok_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ring_link,
  input logic first_n,
  input logic wtok_in_n,
  input logic rtok_in_n,
  input logic wr_last,
  input logic rd_last,
  input logic wtok_out_n,
  input logic rtok_out_n,
  input logic wr_en,
  input logic rd_en,
  input logic aux_en,
  input logic depth_mode,
  input logic proto_err
);
  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(depth_mode));

  assert_standalone_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !depth_mode |-> wr_en && rd_en && wtok_out_n && rtok_out_n && !proto_err);

  assert_wpass_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    depth_mode && !wtok_out_n && wtok_in_n |=> !wr_en);

  assert_rpass_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    depth_mode && !rtok_out_n && rtok_in_n |=> !rd_en);

  assert_wtok_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    depth_mode && !wtok_in_n && !wr_en |=> wr_en);

  assert_dup_wtok_R8: assert property (@(posedge clk) disable iff (!rst_n)
    depth_mode && !wtok_in_n && wr_en && wtok_out_n |=> wr_en && proto_err);

  assert_dup_rtok_R8: assert property (@(posedge clk) disable iff (!rst_n)
    depth_mode && !rtok_in_n && rd_en && rtok_out_n |=> rd_en && proto_err);

  assert_aux_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    aux_en != depth_mode);
endmodule

bind ring_tok_ctrl ring_tok_ctrl_chk chk (.*);

// File: tb/ring_tok_ctrl_test.sv
module ring_tok_ctrl_test;
  logic clk = 0, rst_n = 0, ring_link = 0, first_n = 1;
  logic wtok_in_n = 1, rtok_in_n = 1, wr_last = 0, rd_last = 0;
  logic wtok_out_n, rtok_out_n, wr_en, rd_en, aux_en, depth_mode, proto_err;
  int checks = 0, fails = 0;
  logic mm, mw, mr, me;

  ring_tok_ctrl uut (.*);

  always #2 clk = ~clk;

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic next_tok(logic mode, logic hold, logic last, logic in_n);
    if (!mode) return hold;
    return !in_n | (hold & !last);
  endfunction

  function automatic logic dup(logic mode, logic hold, logic last, logic in_n);
    return mode & !in_n & hold & !last;
  endfunction

  task automatic check_state(string tag);
    chk({tag, " wr_en"}, wr_en, !mm | mw);
    chk({tag, " rd_en"}, rd_en, !mm | mr);
    chk({tag, " aux_en R10"}, aux_en, !mm);
    chk({tag, " depth_mode R1"}, depth_mode, mm);
    chk({tag, " proto_err"}, proto_err, me);
  endtask

  task automatic do_reset(logic link, logic fn);
    @(negedge clk);
    rst_n = 0; ring_link = link; first_n = fn;
    wtok_in_n = 1; rtok_in_n = 1; wr_last = 0; rd_last = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    ring_link = ~link; first_n = ~fn;
    mm = link; mw = link & !fn; mr = link & !fn; me = 0;
    check_state("R2 reset");
  endtask

  task automatic step(logic wl, logic rl, logic wi, logic ri, string tag);
    logic nw, nr, ne;
    wr_last = wl; rd_last = rl; wtok_in_n = wi; rtok_in_n = ri;
    #1;
    chk({tag, " wtok_out_n R4"}, wtok_out_n, !(mm & mw & wl));
    chk({tag, " rtok_out_n R5"}, rtok_out_n, !(mm & mr & rl));
    nw = next_tok(mm, mw, wl, wi);
    nr = next_tok(mm, mr, rl, ri);
    ne = dup(mm, mw, wl, wi) | dup(mm, mr, rl, ri);
    @(posedge clk);
    mw = nw; mr = nr; me = ne;
    @(negedge clk);
    wr_last = 0; rd_last = 0; wtok_in_n = 1; rtok_in_n = 1;
    check_state(tag);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));

    do_reset(1, 0);
    step(1, 0, 1, 1, "R4 write pass");
    chk("R4 token gone", wr_en, 0);
    chk("R11 read kept", rd_en, 1);
    step(1, 0, 1, 1, "R7 wr_last without token");
    step(0, 0, 0, 1, "R6 write token back");
    chk("R6 wr_en", wr_en, 1);
    step(0, 0, 1, 0, "R8 duplicate read token");
    chk("R8 flag", proto_err, 1);
    chk("R8 token kept", rd_en, 1);
    step(0, 0, 1, 1, "R8 flag one cycle");
    chk("R8 flag cleared", proto_err, 0);
    step(1, 1, 0, 0, "R9 loop pass");
    chk("R9 wr kept", wr_en, 1);
    chk("R9 rd kept", rd_en, 1);
    chk("R9 no error", proto_err, 0);
    step(0, 1, 1, 1, "R5 read pass");
    chk("R5 token gone", rd_en, 0);
    chk("R11 write kept", wr_en, 1);

    for (int i = 0; i < 1500; i++)
      step($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
           $urandom_range(0, 5) != 0, $urandom_range(0, 5) != 0, "R6 random ring");

    do_reset(1, 1);
    step(1, 1, 1, 1, "R7 no token");
    for (int i = 0; i < 1000; i++)
      step($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
           $urandom_range(0, 5) != 0, $urandom_range(0, 5) != 0, "R11 random follower");

    do_reset(0, 1);
    for (int i = 0; i < 500; i++)
      step($urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 1), "R3 standalone");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule